// File: doc/BRIEF.md
# Packed Decimal to National Character Converter

This block takes a 128-bit signed packed-decimal operand and rewrites its low seven digits as 16-bit national-format characters. The lowest nibble of the operand is the sign code and each nibble above it is one decimal digit. The result is eight 16-bit characters: the least significant halfword is a sign character and the seven halfwords above it are digit characters. Together with the result the block reports a 4-bit condition field. The field tells whether the value is negative, positive or zero, whether digits were dropped, and whether the operand was malformed.

Requests enter through a valid/ready handshake. Each accepted request gives exactly one response, held in output registers and presented on the following cycle. A stalled response stays stable until the consumer takes it, and a new request is taken in the same cycle the old response leaves.

Top module: `bcd_national_conv`

## Requirements
- R1: Result bits 15:0 are the sign character. It is 0x002D when the sign nibble (operand bits 3:0) is 0xB or 0xD, and 0x002B for any other sign nibble.
- R2: For n = 1 to 7, result halfword n (bits 16n+15:16n) is 0x0030 plus operand nibble n (bits 4n+3:4n), with the upper byte zero. A nibble above 9 is written the same way, giving 0x3A to 0x3F.
- R3: The condition field is ordered LT=bit3, GT=bit2, EQ=bit1, SO=bit0. When the operand is well formed and operand bits 127:4 are all zero, EQ is set and LT and GT are clear.
- R4: When the operand is well formed and the magnitude is non-zero, LT is set for sign nibble 0xB or 0xD and GT is set for sign nibble 0xA, 0xC, 0xE or 0xF. LT, GT and EQ are never set together with each other.
- R5: When the operand is well formed and any of operand bits 127:32 is non-zero, SO is set in addition to the LT/GT/EQ bit, and the seven low digits are still converted.
- R6: When any of nibbles 1 to 7 is above 9, the condition field is exactly 4'b0001.
- R7: When the sign nibble is 0x0 to 0x9, the condition field is exactly 4'b0001.
- R8: The response of an accepted request (in_valid and in_ready both high at a rising edge) appears with out_valid high after that same edge. in_ready is high whenever out_valid is low or out_ready is high. While out_valid is high and out_ready is low, the result and condition stay unchanged.
- R9: While rst_n is low at a rising edge, out_valid is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request carries an operand |
| in_ready | output | 1 | Block can take a request this cycle |
| in_operand | input | 128 | Signed packed-decimal operand, sign in bits 3:0 |
| out_valid | output | 1 | Response registers hold a result |
| out_ready | input | 1 | Consumer takes the response this cycle |
| out_result | output | 128 | Eight national characters, sign character in bits 15:0 |
| out_cond | output | 4 | LT, GT, EQ, SO from bit 3 down to bit 0 |

## Verification
Every state bit of this block is a response register, so a wrong value is visible on out_result, out_cond or out_valid on the cycle after the request that loaded it. A fault in the handshake state shows up at once: a response goes missing, is repeated, or changes while the consumer stalls. The bench checks a stalled response and a replacement request held off during the stall. Classification faults can hide behind other conditions, such as an invalid digit masking the sign, or overflow combined with a zero low part. For that reason the operands mix overflow, bad digits, bad signs and zero magnitudes.

// File: rtl/bcdnat_pkg.sv
// Package: shared constants for the packed-decimal to national converter.
// Assumes 4-bit packed nibbles and an 8-bit zone/digit low byte per character.
package bcdnat_pkg;
    localparam int NIB_W      = 4;
    localparam int COND_W     = 4;
    localparam int COND_LT    = 3;
    localparam int COND_GT    = 2;
    localparam int COND_EQ    = 1;
    localparam int COND_SO    = 0;
    localparam logic [3:0] ZONE_NIB  = 4'h3;
    localparam logic [7:0] MINUS_CH  = 8'h2D;
    localparam logic [7:0] PLUS_CH   = 8'h2B;
    localparam logic [3:0] MAX_DIGIT = 4'd9;
endpackage

// File: rtl/bcdnat_digit.sv
// Module: widens one packed digit nibble into a national digit character.
// Assumes CHAR_W >= 8; flags nibbles that are not decimal digits.
module bcdnat_digit
    import bcdnat_pkg::*;
#(
    parameter int CHAR_W = 16
) (
    input  logic [NIB_W-1:0]  nib,
    output logic [CHAR_W-1:0] chr,
    output logic              bad
);
    localparam int PAD_W = CHAR_W - 8;

    // Build the character: zero upper byte, zone nibble, digit nibble.
    always_comb begin
        chr = {{PAD_W{1'b0}}, ZONE_NIB, nib};
        bad = (nib > MAX_DIGIT);
    end
endmodule

// File: rtl/bcdnat_sign.sv
// Module: decodes the packed sign nibble into polarity, validity and a sign char.
// Assumes codes 0xB/0xD negative, 0xA/0xC/0xE/0xF positive, 0x0-0x9 invalid.
module bcdnat_sign
    import bcdnat_pkg::*;
#(
    parameter int CHAR_W = 16
) (
    input  logic [NIB_W-1:0]  nib,
    output logic              neg,
    output logic              bad,
    output logic [CHAR_W-1:0] chr
);
    localparam int PAD_W = CHAR_W - 8;

    // Classify the sign code and pick the matching character.
    always_comb begin
        neg = 1'b0;
        bad = 1'b0;
        unique case (nib)
            4'hB, 4'hD:             neg = 1'b1;
            4'hA, 4'hC, 4'hE, 4'hF: neg = 1'b0;
            default:                bad = 1'b1;
        endcase
        chr = {{PAD_W{1'b0}}, (neg ? MINUS_CH : PLUS_CH)};
    end
endmodule

// File: rtl/bcdnat_cond.sv
// Module: forms the LT/GT/EQ/SO condition field for one operand.
// Assumes sign in the lowest nibble; digits above OVF_LSB do not fit the result.
module bcdnat_cond
    import bcdnat_pkg::*;
#(
    parameter int OPND_W  = 128,
    parameter int OVF_LSB = 32
) (
    input  logic [OPND_W-1:0] operand,
    input  logic              neg,
    input  logic              malformed,
    output logic [COND_W-1:0] cond
);
    logic mag_zero;
    logic too_wide;

    // Detect a zero magnitude and digits beyond the kept window.
    always_comb begin
        mag_zero = ~|operand[OPND_W-1:NIB_W];
        too_wide = |operand[OPND_W-1:OVF_LSB];
    end

    // Build the field; a malformed operand reports overflow alone.
    always_comb begin
        cond = '0;
        if (malformed) begin
            cond[COND_SO] = 1'b1;
        end else begin
            cond[COND_EQ] = mag_zero;
            cond[COND_LT] = ~mag_zero & neg;
            cond[COND_GT] = ~mag_zero & ~neg;
            cond[COND_SO] = too_wide;
        end
    end
endmodule

// File: rtl/bcd_national_conv.sv
// Module: top of the packed-decimal to national converter with a one-deep
// registered response stage behind a valid/ready handshake.
// Assumes synchronous active-low reset; data registers need no reset since
// they are only observed while out_valid is high.
module bcd_national_conv
    import bcdnat_pkg::*;
#(
    parameter int OPND_W      = 128,
    parameter int KEPT_DIGITS = 7,
    parameter int CHAR_W      = 16,
    localparam int RES_W      = (KEPT_DIGITS + 1) * CHAR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [OPND_W-1:0] in_operand,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [RES_W-1:0]  out_result,
    output logic [3:0]        out_cond
);
    localparam int OVF_LSB = (KEPT_DIGITS + 1) * NIB_W;
    localparam logic [CHAR_W-1:0] ZERO_CHAR = {{(CHAR_W-8){1'b0}}, ZONE_NIB, 4'h0};

    logic [RES_W-1:0]       next_result;
    logic [KEPT_DIGITS-1:0] digit_bad;
    logic                   sign_neg;
    logic                   sign_bad;
    logic [COND_W-1:0]      next_cond;
    logic                   accept;

    // Sign nibble decode and sign character in halfword 0.
    bcdnat_sign #(.CHAR_W(CHAR_W)) u_sign (
        .nib (in_operand[NIB_W-1:0]),
        .neg (sign_neg),
        .bad (sign_bad),
        .chr (next_result[CHAR_W-1:0])
    );

    // One digit converter per kept digit; halfword n carries nibble n.
    for (genvar g = 1; g <= KEPT_DIGITS; g++) begin : g_digit
        bcdnat_digit #(.CHAR_W(CHAR_W)) u_digit (
            .nib (in_operand[g*NIB_W +: NIB_W]),
            .chr (next_result[g*CHAR_W +: CHAR_W]),
            .bad (digit_bad[g-1])
        );
    end

    bcdnat_cond #(.OPND_W(OPND_W), .OVF_LSB(OVF_LSB)) u_cond (
        .operand   (in_operand),
        .neg       (sign_neg),
        .malformed (sign_bad | (|digit_bad)),
        .cond      (next_cond)
    );

    // Handshake: a slot is free when empty or being drained this cycle.
    always_comb begin
        in_ready = ~out_valid | out_ready;
        accept   = in_valid & in_ready;
    end

    // Response valid flag: set on accept, cleared when taken or on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
        end else if (accept) begin
            out_valid <= 1'b1;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    // Response data: load only on accept so a stalled response holds.
    always_ff @(posedge clk) begin
        if (accept) begin
            out_result <= next_result;
            out_cond   <= next_cond;
        end
    end

    // R8: a stalled response stays put.
    a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !in_valid) |=> (out_valid && $stable(out_result) && $stable(out_cond)));

    // R8: an accepted request is answered after the same edge.
    a_r8_accept_answers: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    // R4: the polarity/zero bits never combine.
    a_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $onehot0(out_cond[COND_LT:COND_EQ]));

    // R1: a negative result carries the minus character.
    a_r1_lt_minus: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_cond[COND_LT]) |-> (out_result[7:0] == MINUS_CH));

    // R3: a zero result has all-zero digit characters.
    for (genvar g = 1; g <= KEPT_DIGITS; g++) begin : g_chk
        a_r3_eq_zero_digits: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && out_cond[COND_EQ]) |-> (out_result[g*CHAR_W +: CHAR_W] == ZERO_CHAR));
    end
endmodule

// File: tb/bcd_national_conv_test.sv
`timescale 1ns/1ps
module bcd_national_conv_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [127:0] in_operand = '0;
    logic         out_valid;
    logic         out_ready = 1'b0;
    logic [127:0] out_result;
    logic [3:0]   out_cond;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    bcd_national_conv uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_operand(in_operand), .out_valid(out_valid), .out_ready(out_ready),
        .out_result(out_result), .out_cond(out_cond)
    );

    function automatic logic [127:0] exp_result(input logic [127:0] op);
        logic [127:0] r;
        r = '0;
        r[15:0] = (op[3:0] == 4'hB || op[3:0] == 4'hD) ? 16'h002D : 16'h002B;
        for (int n = 1; n <= 7; n++) r[16*n +: 16] = 16'h0030 + {12'h0, op[4*n +: 4]};
        return r;
    endfunction

    function automatic logic [3:0] exp_cond(input logic [127:0] op);
        logic bad;
        logic neg;
        bad = (op[3:0] <= 4'h9);
        for (int n = 1; n <= 7; n++) if (op[4*n +: 4] > 4'h9) bad = 1'b1;
        if (bad) return 4'b0001;
        neg = (op[3:0] == 4'hB || op[3:0] == 4'hD);
        if (op[127:4] == '0) return 4'b0010;
        return {neg, ~neg, 1'b0, (op[127:32] != '0)};
    endfunction

    function automatic string cond_tag(input logic [127:0] op);
        bit baddig;
        baddig = 0;
        for (int n = 1; n <= 7; n++) if (op[4*n +: 4] > 4'h9) baddig = 1;
        if (baddig) return "R6";
        if (op[3:0] <= 4'h9) return "R7";
        if (op[127:32] != '0) return "R5";
        if (op[127:4] == '0) return "R3";
        return "R4";
    endfunction

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_resp(input logic [127:0] op);
        logic [127:0] er;
        er = exp_result(op);
        check("R8 out_valid", {127'h0, out_valid}, 128'h1);
        check("R1 sign char", {112'h0, out_result[15:0]}, {112'h0, er[15:0]});
        check("R2 digit chars", {16'h0, out_result[127:16]}, {16'h0, er[127:16]});
        check(cond_tag(op), {124'h0, out_cond}, {124'h0, exp_cond(op)});
    endtask

    // one request accepted at the next edge, response checked half a cycle later
    task automatic send(input logic [127:0] op);
        @(negedge clk);
        in_operand = op;
        in_valid   = 1'b1;
        out_ready  = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check_resp(op);
    endtask

    function automatic logic [127:0] rand_op();
        logic [127:0] op;
        int k;
        op = '0;
        for (int n = 1; n < 32; n++) op[4*n +: 4] = 4'($urandom_range(0, 9));
        k = $urandom_range(0, 15);
        op[3:0] = (k < 2) ? 4'($urandom_range(0, 9)) : 4'($urandom_range(10, 15));
        if ($urandom_range(0, 3) != 0) op[127:32] = '0;
        if ($urandom_range(0, 9) == 0) op[4*$urandom_range(1, 7) +: 4] = 4'($urandom_range(10, 15));
        if ($urandom_range(0, 15) == 0) op[127:4] = '0;
        return op;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [127:0] a;
        logic [127:0] b;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9 out_valid in reset", {127'h0, out_valid}, 128'h0);
        check("R8 in_ready when empty", {127'h0, in_ready}, 128'h1);
        @(negedge clk);
        rst_n = 1'b1;

        // directed corners
        send(128'h0000_0000_0000_0000_0000_0000_1234_567C); // R4 positive
        send(128'h0000_0000_0000_0000_0000_0000_9876_543D); // R4 negative
        send(128'h0000_0000_0000_0000_0000_0000_0000_000B); // R3 negative zero
        send(128'h0000_0000_0000_0000_0000_0000_0000_000F); // R3 positive zero
        send(128'h0000_0000_0000_0000_0000_0009_0000_000A); // R5 overflow, low part zero
        send(128'h9000_0000_0000_0000_0000_0000_0000_005E); // R5 top digit
        send(128'h0000_0000_0000_0000_0000_0000_0000_0A1C); // R6 bad digit 2
        send(128'h0000_0000_0000_0000_0000_0000_F000_000D); // R6 bad digit 7
        send(128'h0000_0000_0000_0000_0000_0000_0000_0125); // R7 bad sign
        send(128'h0000_0000_0000_0000_0000_0000_0000_0000); // R7 sign zero

        // R8: stall holds the response and blocks a second request
        a = 128'h0000_0000_0000_0000_0000_0000_7654_321B;
        b = 128'h0000_0000_0000_0000_0000_0000_1111_222C;
        @(negedge clk);
        in_operand = a; in_valid = 1'b1; out_ready = 1'b0;
        @(negedge clk);
        in_operand = b;
        check_resp(a);
        check("R8 in_ready low on stall", {127'h0, in_ready}, 128'h0);
        @(negedge clk);
        check_resp(a);
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check_resp(b);
        @(negedge clk);
        check("R8 drained", {127'h0, out_valid}, 128'h0);

        // R9: reset mid-response
        in_operand = a; in_valid = 1'b1; out_ready = 1'b0;
        @(negedge clk);
        in_valid = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        check("R9 reset clears valid", {127'h0, out_valid}, 128'h0);
        rst_n = 1'b1;

        // random mix, back to back
        for (int i = 0; i < 400; i++) send(rand_op());

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule